// File: doc/BRIEF.md
# Predicated Flag-Setting Integer ALU

This block is the execute-stage integer unit of a small processor pipeline. Each cycle it may accept one data-processing operation: a 4-bit operation code, a first operand, a second operand that an upstream shifter has already prepared, the shifter's carry-out, a set-flags request and a 4-bit predicate code. The block keeps the four condition flags (negative, zero, carry, overflow) in its own register. It tests the predicate against those flags and decides whether the operation takes effect. When the operation takes effect, the block produces a registered result with a write strobe, updates the flags, or does both.

The operation set covers six additive forms, including reverse subtraction and the carry-chained variants. It also covers four bitwise forms, including AND with an inverted second operand, two moves, and four flag-only comparisons. A predicate that fails cancels both the write and the flag update. Because the flags are registered, an operation that depends on them sees the flags left by the operation accepted one cycle earlier.

Top module: `flagAlu`

## Requirements
- R1: Additive operations write, with codes ADD=4 (a+b), ADC=5 (a+b+C), SUB=2 (a-b), SBC=6 (a-b-NOT C), RSB=3 (b-a), RSC=7 (b-a-NOT C), all modulo 2^32.
- R2: Bitwise operations write, with codes AND=0 (a&b), XOR=1 (a^b), OR=12 (a|b), BIC=14 (a & ~b).
- R3: MOV=13 writes b and MVN=15 writes ~b; the first operand has no effect on either.
- R4: The compare codes TST=8 (as AND), TEQ=9 (as XOR), CMP=10 (as SUB) and CMN=11 (as ADD) always update the flags and never assert resWrite.
- R5: Any non-compare operation with setFlags=0 leaves flagsOut unchanged.
- R6: When flags update, N equals result bit 31 and Z is set exactly when the 32-bit result is zero. flagsOut is {N,Z,C,V}, with N on bit 3 and V on bit 0.
- R7: On additive updates, C is the unsigned carry out of the addition. For a subtraction C means no borrow. V is set on two's-complement overflow.
- R8: On bitwise, move or test updates, C takes shiftCarry and V keeps its previous value.
- R9: The predicate codes are EQ=0 (Z), NE=1 (!Z), HS=2 (C), LO=3 (!C), MI=4 (N), PL=5 (!N), VS=6 (V), VC=7 (!V), HI=8 (C&!Z), LS=9 (!C|Z), GE=10 (N==V), LT=11 (N!=V), GT=12 (!Z&N==V), LE=13 (Z|N!=V), AL=14 (always) and NV=15 (never).
- R10: A failed predicate leaves resWrite low, resValue unchanged and flagsOut unchanged.
- R11: Results appear on resValue and resWrite on the clock after the operation is accepted. resValue holds its last written value. resWrite is low when opValid is low. Reset clears resValue, resWrite and flagsOut to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| setFlags | input | 1 | Request flag update for non-compare operations |
| condCode | input | 4 | Predicate code |
| opA | input | 32 | First operand |
| opB | input | 32 | Pre-shifted second operand |
| shiftCarry | input | 1 | Carry-out of the upstream shifter |
| resValue | output | 32 | Registered result |
| resWrite | output | 1 | Result write strobe, one cycle |
| flagsOut | output | 4 | Flag register {N,Z,C,V} |

## Verification
The main interaction is between the predicate check and the flag update. An operation can change the flags in the same cycle that the next operation, already at the inputs, is being judged against the old flags. It can also set flags and have its own predicate fail at once. The bench provokes this with back-to-back operations: a flag-setting compare or arithmetic step followed at once by predicated moves across all sixteen codes. It then adds a long stream of mixed operations with boundary operands. A behavioural model tracks the flags cycle by cycle and predicts each write strobe, result and flag value. Those predictions are compared on every clock.

// File: rtl/flagAluPkg.sv
package flagAluPkg;
  localparam int OP_W   = 4;
  localparam int COND_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 4'd0,  OP_XOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } aluOp_e;

  typedef enum logic [1:0] {CIN_ZERO = 2'd0, CIN_ONE = 2'd1, CIN_FLAG = 2'd2} cinSel_e;

  typedef enum logic [2:0] {
    LF_AND = 3'd0, LF_XOR = 3'd1, LF_ORR = 3'd2, LF_MOV = 3'd3, LF_BIC = 3'd4, LF_MVN = 3'd5
  } logicFn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } aluFlags_t;

  typedef struct packed {
    logic     wrRes;
    logic     wrFlags;
    logic     arith;
    logic     swapOps;
    logic     invSecond;
    cinSel_e  cinSel;
    logicFn_e logicFn;
  } aluStrobe_t;
endpackage

// File: rtl/flagAluCtrl.sv
module flagAluCtrl
  import flagAluPkg::*;
(
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              setFlags,
  input  logic [COND_W-1:0] condCode,
  input  aluFlags_t         flags,
  output aluStrobe_t        strobe
);
  logic condPass;
  logic isCompare;
  logic execute;

  always_comb begin
    unique case (condCode)
      4'd0:    condPass = flags.z;
      4'd1:    condPass = !flags.z;
      4'd2:    condPass = flags.c;
      4'd3:    condPass = !flags.c;
      4'd4:    condPass = flags.n;
      4'd5:    condPass = !flags.n;
      4'd6:    condPass = flags.v;
      4'd7:    condPass = !flags.v;
      4'd8:    condPass = flags.c && !flags.z;
      4'd9:    condPass = !flags.c || flags.z;
      4'd10:   condPass = flags.n == flags.v;
      4'd11:   condPass = flags.n != flags.v;
      4'd12:   condPass = !flags.z && (flags.n == flags.v);
      4'd13:   condPass = flags.z || (flags.n != flags.v);
      4'd14:   condPass = 1'b1;
      default: condPass = 1'b0;
    endcase
  end

  assign isCompare = (opCode[3:2] == 2'b10);
  assign execute   = opValid && condPass;

  always_comb begin
    strobe           = '0;
    strobe.wrRes     = execute && !isCompare;
    strobe.wrFlags   = execute && (setFlags || isCompare);
    strobe.cinSel    = CIN_ZERO;
    strobe.logicFn   = LF_AND;
    unique case (aluOp_e'(opCode))
      OP_ADD, OP_CMN: strobe.arith = 1'b1;
      OP_ADC: begin strobe.arith = 1'b1; strobe.cinSel = CIN_FLAG; end
      OP_SUB, OP_CMP: begin strobe.arith = 1'b1; strobe.invSecond = 1'b1; strobe.cinSel = CIN_ONE; end
      OP_SBC: begin strobe.arith = 1'b1; strobe.invSecond = 1'b1; strobe.cinSel = CIN_FLAG; end
      OP_RSB: begin
        strobe.arith = 1'b1; strobe.swapOps = 1'b1; strobe.invSecond = 1'b1; strobe.cinSel = CIN_ONE;
      end
      OP_RSC: begin
        strobe.arith = 1'b1; strobe.swapOps = 1'b1; strobe.invSecond = 1'b1; strobe.cinSel = CIN_FLAG;
      end
      OP_AND, OP_TST: strobe.logicFn = LF_AND;
      OP_XOR, OP_TEQ: strobe.logicFn = LF_XOR;
      OP_ORR:         strobe.logicFn = LF_ORR;
      OP_MOV:         strobe.logicFn = LF_MOV;
      OP_BIC:         strobe.logicFn = LF_BIC;
      default:        strobe.logicFn = LF_MVN;
    endcase
  end
endmodule

// File: rtl/flagAluDatapath.sv
module flagAluDatapath
  import flagAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             shiftCarry,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] resValue,
  output logic             resWrite,
  output aluFlags_t        flags
);
  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] addX, addYRaw, addY, logicRes, result;
  logic [SUM_W-1:0] sumWide;
  logic             carryIn, arithV;
  aluFlags_t        nextFlags;

  assign addX    = strobe.swapOps ? opB : opA;
  assign addYRaw = strobe.swapOps ? opA : opB;
  assign addY    = strobe.invSecond ? ~addYRaw : addYRaw;

  always_comb begin
    unique case (strobe.cinSel)
      CIN_ONE:  carryIn = 1'b1;
      CIN_FLAG: carryIn = flags.c;
      default:  carryIn = 1'b0;
    endcase
  end

  assign sumWide = {1'b0, addX} + {1'b0, addY} + {{WIDTH{1'b0}}, carryIn};
  assign arithV  = (addX[WIDTH-1] == addY[WIDTH-1]) && (sumWide[WIDTH-1] != addX[WIDTH-1]);

  always_comb begin
    unique case (strobe.logicFn)
      LF_AND:  logicRes = opA & opB;
      LF_XOR:  logicRes = opA ^ opB;
      LF_ORR:  logicRes = opA | opB;
      LF_MOV:  logicRes = opB;
      LF_BIC:  logicRes = opA & ~opB;
      default: logicRes = ~opB;
    endcase
  end

  assign result = strobe.arith ? sumWide[WIDTH-1:0] : logicRes;

  always_comb begin
    nextFlags.n = result[WIDTH-1];
    nextFlags.z = (result == '0);
    nextFlags.c = strobe.arith ? sumWide[WIDTH] : shiftCarry;
    nextFlags.v = strobe.arith ? arithV : flags.v;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValue <= '0;
      resWrite <= 1'b0;
      flags    <= '0;
    end else begin
      resWrite <= strobe.wrRes;
      if (strobe.wrRes)   resValue <= result;
      if (strobe.wrFlags) flags    <= nextFlags;
    end
  end

  AST_SKIP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.wrRes && !strobe.wrFlags) |=> ($stable(flags) && $stable(resValue) && !resWrite)); // R10
  AST_ZERO_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrRes && strobe.wrFlags) |=> ((flags.z == (resValue == '0)) && (flags.n == resValue[WIDTH-1]))); // R6
  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrFlags && !strobe.arith) |=> (flags.v == $past(flags.v))); // R8
endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import flagAluPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              setFlags,
  input  logic [COND_W-1:0] condCode,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              shiftCarry,
  output logic [WIDTH-1:0]  resValue,
  output logic              resWrite,
  output logic [3:0]        flagsOut
);
  aluStrobe_t strobe;
  aluFlags_t  flags;

  flagAluCtrl uCtrl (
    .opValid (opValid),
    .opCode  (opCode),
    .setFlags(setFlags),
    .condCode(condCode),
    .flags   (flags),
    .strobe  (strobe)
  );

  flagAluDatapath #(.WIDTH(WIDTH)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .shiftCarry(shiftCarry),
    .strobe    (strobe),
    .resValue  (resValue),
    .resWrite  (resWrite),
    .flags     (flags)
  );

  assign flagsOut = flags;

  AST_CMP_NEVER_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode[3:2] == 2'b10) |=> !resWrite); // R4
  AST_NO_S_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !setFlags && opCode[3:2] != 2'b10) |=> $stable(flagsOut)); // R5
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !resWrite); // R11
endmodule

// File: tb/flagAlu_test.sv
module flagAlu_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic        setFlags = 1'b0;
  logic [3:0]  condCode = 4'd14;
  logic [31:0] opA = '0, opB = '0;
  logic        shiftCarry = 1'b0;
  logic [31:0] resValue;
  logic        resWrite;
  logic [3:0]  flagsOut;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic        mN = 0, mZ = 0, mC = 0, mV = 0;
  logic [31:0] expRes = '0;
  logic        expWr = 1'b0;
  string       tagFlags, tagWr, tagRes;
  logic        expectNZ;

  always #10 clk = ~clk;

  flagAlu uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .setFlags(setFlags),
    .condCode(condCode), .opA(opA), .opB(opB), .shiftCarry(shiftCarry),
    .resValue(resValue), .resWrite(resWrite), .flagsOut(flagsOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic condOk(input logic [3:0] cc);
    case (cc)
      4'd0: return mZ;            4'd1: return !mZ;
      4'd2: return mC;            4'd3: return !mC;
      4'd4: return mN;            4'd5: return !mN;
      4'd6: return mV;            4'd7: return !mV;
      4'd8: return mC && !mZ;     4'd9: return !mC || mZ;
      4'd10: return mN == mV;     4'd11: return mN != mV;
      4'd12: return !mZ && mN == mV;
      4'd13: return mZ || mN != mV;
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ovf(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // Apply one operation at a falling edge, predict, then check at the next falling edge.
  task automatic doOp(input logic v, input logic [3:0] op, input logic s, input logic [3:0] cc,
                      input logic [31:0] a, input logic [31:0] b, input logic sc);
    logic pass, exec, isCmp, arith, c, ov;
    logic [31:0] r;
    longint ua, ub, sa, sb, bor, cin, w;
    ua = longint'({32'b0, a}); ub = longint'({32'b0, b});
    sa = longint'(signed'(a)); sb = longint'(signed'(b));
    cin = mC ? 1 : 0; bor = mC ? 0 : 1;
    pass = condOk(cc); exec = v && pass; isCmp = (op >= 4'd8 && op <= 4'd11);
    arith = 1'b1; c = 1'b0; ov = 1'b0; r = '0;
    case (op)
      4'd4, 4'd11: begin w = ua + ub; r = w[31:0]; c = w > 64'hFFFFFFFF; ov = ovf(sa + sb); end
      4'd5:  begin w = ua + ub + cin; r = w[31:0]; c = w > 64'hFFFFFFFF; ov = ovf(sa + sb + cin); end
      4'd2, 4'd10: begin r = a - b; c = ua >= ub; ov = ovf(sa - sb); end
      4'd6:  begin r = a - b - 32'(bor); c = ua >= ub + bor; ov = ovf(sa - sb - bor); end
      4'd3:  begin r = b - a; c = ub >= ua; ov = ovf(sb - sa); end
      4'd7:  begin r = b - a - 32'(bor); c = ub >= ua + bor; ov = ovf(sb - sa - bor); end
      default: begin
        arith = 1'b0;
        case (op)
          4'd0, 4'd8: r = a & b;
          4'd1, 4'd9: r = a ^ b;
          4'd12: r = a | b;
          4'd13: r = b;
          4'd14: r = a & ~b;
          default: r = ~b;
        endcase
      end
    endcase
    if (!v) begin tagWr = "R11"; tagFlags = "R11"; end
    else if (!pass) begin tagWr = "R10"; tagFlags = "R10"; end
    else begin
      tagWr = (cc != 4'd14) ? "R9" : (isCmp ? "R4" : "R11");
      if (isCmp) tagFlags = "R4";
      else if (!s) tagFlags = "R5";
      else tagFlags = arith ? "R7" : "R8";
    end
    tagRes = arith ? "R1" : ((op == 4'd13 || op == 4'd15) ? "R3" : "R2");
    if (!exec || isCmp) tagRes = (!v) ? "R11" : (!pass ? "R10" : "R4");
    expWr = exec && !isCmp;
    if (expWr) expRes = r;
    expectNZ = exec && (s || isCmp);
    if (expectNZ) begin
      mN = r[31]; mZ = (r == 32'd0);
      if (arith) begin mC = c; mV = ov; end
      else mC = sc;
    end
    opValid = v; opCode = op; setFlags = s; condCode = cc; opA = a; opB = b; shiftCarry = sc;
    @(negedge clk);
    check(tagWr, {31'b0, resWrite}, {31'b0, expWr});
    check(tagRes, resValue, expRes);
    check(tagFlags, {28'b0, flagsOut}, {28'b0, mN, mZ, mC, mV});
    if (expectNZ) check("R6", {30'b0, flagsOut[3:2]}, {30'b0, mN, mZ});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h8000_0000;
      2: return 32'h7FFF_FFFF;
      3: return 32'hFFFF_FFFF;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", resValue, 32'h0);
    check("R11", {31'b0, resWrite}, 32'h0);
    check("R11", {28'b0, flagsOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R7 boundaries
    doOp(1, 4'd4, 1, 14, 32'h7FFF_FFFF, 32'h1, 0);          // ADD overflow: N V set
    doOp(1, 4'd4, 1, 14, 32'hFFFF_FFFF, 32'h1, 0);          // ADD carry, zero
    doOp(1, 4'd5, 1, 14, 32'h10, 32'h20, 0);                // ADC with C=1 -> 0x31
    doOp(1, 4'd2, 1, 14, 32'h0, 32'h1, 0);                  // SUB borrow: C=0
    doOp(1, 4'd6, 1, 14, 32'h10, 32'h3, 0);                 // SBC with C=0 -> 0xC
    doOp(1, 4'd3, 1, 14, 32'h5, 32'h2, 0);                  // RSB -> -3
    doOp(1, 4'd7, 1, 14, 32'h1, 32'h9, 0);                  // RSC
    doOp(1, 4'd2, 1, 14, 32'h8000_0000, 32'h1, 0);          // SUB signed overflow
    // R2 / R3 / R8
    doOp(1, 4'd14, 1, 14, 32'hFFFF_00FF, 32'h0000_00A5, 1); // BIC, C from shifter
    doOp(1, 4'd13, 0, 14, 32'hDEAD_BEEF, 32'h1234_5678, 0); // MOV ignores opA
    doOp(1, 4'd15, 1, 14, 32'h0BAD_F00D, 32'hFFFF_FFFF, 0); // MVN -> zero
    doOp(1, 4'd13, 0, 14, 32'h0, 32'h1234_5678, 0);         // MOV with other opA, same result
    // R4 compare then every predicate back to back (R9 / R10)
    for (int cc = 0; cc < 16; cc++) begin
      doOp(1, 4'd10, 0, 14, 32'h3, 32'h5, 0);               // CMP: N=1 C=0
      doOp(1, 4'd13, 0, 4'(cc), 32'h0, 32'(cc + 100), 0);
      doOp(1, 4'd11, 0, 14, 32'h7FFF_FFFF, 32'h1, 0);       // CMN: N=1 V=1
      doOp(1, 4'd13, 1, 4'(cc), 32'h0, 32'(cc), 1);
      doOp(1, 4'd8, 0, 14, 32'h0F, 32'hF0, 1);              // TST zero: Z=1 C=1
      doOp(1, 4'd15, 0, 4'(cc), 32'h0, 32'(cc), 0);
      doOp(1, 4'd9, 0, 4'(cc), 32'h1, 32'h1, 0);            // TEQ predicated
    end
    // R5 no S, idle R11
    doOp(1, 4'd4, 0, 14, 32'hFFFF_FFFF, 32'h1, 0);
    doOp(0, 4'd4, 1, 14, 32'h1, 32'h1, 0);
    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      doOp($urandom_range(0, 9) != 0, 4'($urandom), 1'($urandom), 4'($urandom_range(0, 3) == 0 ? 14 : $urandom),
           pick(), pick(), 1'($urandom));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R11: watchdog expired, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule